// File: doc/BRIEF.md
# Buffered-Configuration Crosspoint Switch

A non-blocking crosspoint with 34 data inputs and 34 data outputs. Each output is a wide multiplexer whose select comes from that output's active configuration register. The data path is purely combinational: no register and no clock lie between `din` and `dout`. Any input can feed any number of outputs at the same time.

Configuration goes through a small parallel port with an address, write data, read data, and separate write and read strobes, all sampled on `clk`. A write to an output entry only changes that output's pending (shadow) select. The outputs are untouched until a write to the control address. That write copies every pending select into the active bank in a single edge, so a whole new routing pattern takes effect at once. Both banks can be read back.

The address has three fields. Bits [5:0] hold the output index. Bits [7:6] select the space:
- 00 is the pending bank. It can be read and written.
- 01 is the active bank. It can only be read.
- 10 is control. Address 0x80 is the configure command.
- 11 is reserved.

Top module: `xbar_switch`

## Requirements
- R1: After reset, pending select n and active select n both hold n for every output n, so `dout` equals `din`.
- R2: Every output n always carries `din[active select n]`. A change on `din` shows on `dout` in the same time step, with no clock edge between them.
- R3: A single input may be selected by any number of outputs at once, and all of them follow it.
- R4: A write with `addr[7:6]`=00, index `addr[5:0]` below 34 and `wdata` below 34 stores `wdata` as that output's pending select at the clock edge.
- R5: Pending writes never change the active selects or `dout`. Only the configure command does.
- R6: A write to address 0x80 copies all 34 pending selects into the active bank at that edge, and any write data is disregarded. Repeating the command with no new pending writes leaves the routing as it is.
- R7: A write whose index is 34 or more, whose data is 34 or more, or whose space is 01 or 11 changes no pending select, no active select and no output. A control-space write other than 0x80 does the same.
- R8: A read strobe loads `rd_data` at the edge with the value addressed. Space 00 returns the pending select and space 01 returns the active select. An index of 34 or more, or space 10 or 11, returns 0. Without a read strobe, `rd_data` holds its value.
- R9: A read and a write to the same pending entry in one cycle return the select held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Space in [7:6], output index in [5:0] |
| wdata | input | 6 | Input index to store as a select |
| rd_data | output | 6 | Registered readback value |
| din | input | 34 | Data inputs |
| dout | output | 34 | Data outputs |

## Verification
Two of the block's functions can meet in one cycle. A read strobe and a write strobe can be raised together on the same pending entry. The bench does this on several entries and expects the readback to show the old select, with the new select visible on the following read.

A second overlap is between queued writes and the live routing. Many pending writes are made between two configure commands. After each batch, the bench sweeps a one-hot walk over all 34 inputs and compares every output with the active mapping that its model predicts.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    // Address space field, taken from the two bits above the output index
    typedef enum logic [1:0] {
        SPC_PEND = 2'b00,
        SPC_ACT  = 2'b01,
        SPC_CTRL = 2'b10,
        SPC_RSVD = 2'b11
    } addr_space_e;
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_pkg::*;
#(
    parameter int NUM_IN  = 34,
    parameter int NUM_OUT = 34,
    parameter int SEL_W   = $clog2(NUM_IN),
    parameter int IDX_W   = $clog2(NUM_OUT),
    parameter int ADDR_W  = IDX_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [SEL_W-1:0]               wdata,
    output logic [NUM_OUT-1:0][SEL_W-1:0]  pend_o,
    output logic [NUM_OUT-1:0][SEL_W-1:0]  act_o
);
    typedef struct packed {
        logic [NUM_OUT-1:0][SEL_W-1:0] pend;
        logic [NUM_OUT-1:0][SEL_W-1:0] act;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    addr_space_e      space;
    logic [IDX_W-1:0] idx;
    logic             idx_ok, data_ok, cfg_cmd;

    assign space   = addr_space_e'(addr[ADDR_W-1:IDX_W]);
    assign idx     = addr[IDX_W-1:0];
    assign idx_ok  = {1'b0, idx}   < (IDX_W+1)'(NUM_OUT);
    assign data_ok = {1'b0, wdata} < (SEL_W+1)'(NUM_IN);
    assign cfg_cmd = wr_en && (space == SPC_CTRL) && (idx == '0);

    always_comb begin
        state_d = state_q;
        if (wr_en && space == SPC_PEND && idx_ok && data_ok) begin
            state_d.pend[idx] = wdata;
        end
        if (cfg_cmd) begin
            state_d.act = state_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_OUT; n++) begin
                state_q.pend[n] <= SEL_W'(n % NUM_IN);
                state_q.act[n]  <= SEL_W'(n % NUM_IN);
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o = state_q.pend;
    assign act_o  = state_q.act;
endmodule

// File: rtl/xbar_rd_port.sv
module xbar_rd_port
    import xbar_pkg::*;
#(
    parameter int NUM_OUT = 34,
    parameter int SEL_W   = 6,
    parameter int IDX_W   = $clog2(NUM_OUT),
    parameter int ADDR_W  = IDX_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]  pend_i,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]  act_i,
    output logic [SEL_W-1:0]               rd_data
);
    logic [SEL_W-1:0] rd_d, rd_q;
    addr_space_e      space;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;

    assign space  = addr_space_e'(addr[ADDR_W-1:IDX_W]);
    assign idx    = addr[IDX_W-1:0];
    assign idx_ok = {1'b0, idx} < (IDX_W+1)'(NUM_OUT);

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = '0;
            if (idx_ok && space == SPC_PEND) rd_d = pend_i[idx];
            if (idx_ok && space == SPC_ACT)  rd_d = act_i[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/xbar_mux_array.sv
module xbar_mux_array #(
    parameter int NUM_IN  = 34,
    parameter int NUM_OUT = 34,
    parameter int SEL_W   = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0]              din,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]  sel,
    output logic [NUM_OUT-1:0]             dout
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        always_comb begin
            dout[o] = 1'b0;
            for (int i = 0; i < NUM_IN; i++) begin
                if (sel[o] == SEL_W'(i)) dout[o] = din[i];
            end
        end
    end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
    parameter int NUM_IN  = 34,
    parameter int NUM_OUT = 34,
    parameter int SEL_W   = $clog2(NUM_IN),
    parameter int IDX_W   = $clog2(NUM_OUT),
    parameter int ADDR_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  wdata,
    output logic [SEL_W-1:0]  rd_data,
    input  logic [NUM_IN-1:0] din,
    output logic [NUM_OUT-1:0] dout
);
    logic [NUM_OUT-1:0][SEL_W-1:0] pend_sel, act_sel;

    xbar_cfg_regs #(
        .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W),
        .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .pend_o(pend_sel), .act_o(act_sel)
    );

    xbar_rd_port #(
        .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .pend_i(pend_sel), .act_i(act_sel), .rd_data(rd_data)
    );

    xbar_mux_array #(
        .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)
    ) u_mux (
        .din(din), .sel(act_sel), .dout(dout)
    );
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
    parameter int NUM_IN  = 34,
    parameter int NUM_OUT = 34,
    parameter int SEL_W   = $clog2(NUM_IN),
    parameter int IDX_W   = $clog2(NUM_OUT),
    parameter int ADDR_W  = IDX_W + 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [SEL_W-1:0]              wdata,
    input logic [SEL_W-1:0]              rd_data,
    input logic [NUM_OUT-1:0][SEL_W-1:0] pend_flat,
    input logic [NUM_OUT-1:0][SEL_W-1:0] act_flat
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = {2'b10, {IDX_W{1'b0}}};

    logic cfg_hit, bad_wr;
    assign cfg_hit = wr_en && (addr == CFG_ADDR);
    assign bad_wr  = wr_en && (addr[ADDR_W-1:IDX_W] != 2'b00 ||
                     {1'b0, addr[IDX_W-1:0]} >= (IDX_W+1)'(NUM_OUT) ||
                     {1'b0, wdata} >= (SEL_W+1)'(NUM_IN));

    // R6: configure command copies the pending bank into the active bank
    assert_cfg_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> act_flat == $past(pend_flat));

    // R5: active bank is held without a configure command
    assert_act_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> $stable(act_flat));

    // R7: rejected writes leave the pending bank untouched
    assert_bad_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> $stable(pend_flat));

    // R8: readback register holds without a read strobe
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7: no select outside the input range ever gets stored
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_rng
        assert_sel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, act_flat[o]} < (SEL_W+1)'(NUM_IN)) &&
            ({1'b0, pend_flat[o]} < (SEL_W+1)'(NUM_IN)));
    end
endmodule

bind xbar_switch xbar_switch_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .pend_flat(pend_sel), .act_flat(act_sel)
);

// File: tb/xbar_switch_tb.sv
module xbar_switch_tb;
    localparam int N = 34;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [5:0]   wdata = '0;
    logic [5:0]   rd_data;
    logic [N-1:0] din = '0;
    logic [N-1:0] dout;

    int exp_pend [N];
    int exp_act  [N];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    xbar_switch u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .din(din), .dout(dout)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one port cycle; model updated per R4/R6/R7
    task automatic access(input logic wr, input logic rd, input logic [7:0] a,
                          input logic [5:0] d, output logic [5:0] rv);
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = d;
        @(negedge clk);
        rv = rd_data;
        wr_en = 0; rd_en = 0;
        if (wr && a[7:6] == 2'b00 && a[5:0] < N && d < N) exp_pend[a[5:0]] = d;
        if (wr && a == 8'h80) for (int k = 0; k < N; k++) exp_act[k] = exp_pend[k];
    endtask

    task automatic wr(input logic [7:0] a, input logic [5:0] d);
        logic [5:0] dummy;
        access(1'b1, 1'b0, a, d, dummy);
    endtask

    function automatic logic [N-1:0] route(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int o = 0; o < N; o++) r[o] = v[exp_act[o]];
        return r;
    endfunction

    // one-hot walk over all inputs, plus two dense patterns, no clock edge needed
    task automatic sweep(input string req);
        for (int i = 0; i < N; i++) begin
            din = N'(1) << i;
            #1 check(req, dout, route(din));
        end
        din = 34'h2_AAAA_5555; #1 check(req, dout, route(din));
        din = ~din;             #1 check(req, dout, route(din));
    endtask

    task automatic read_all(input string req);
        logic [5:0] rv;
        for (int o = 0; o < N; o++) begin
            access(1'b0, 1'b1, {2'b00, 6'(o)}, 6'd0, rv); check(req, rv, exp_pend[o]);
            access(1'b0, 1'b1, {2'b01, 6'(o)}, 6'd0, rv); check(req, rv, exp_act[o]);
        end
    endtask

    initial begin
        logic [5:0] rv;
        for (int k = 0; k < N; k++) begin exp_pend[k] = k; exp_act[k] = k; end
        repeat (3) @(negedge clk);
        check("R8 reset rd_data", rd_data, 0);
        rst_n = 1'b1;

        // R1: identity after reset
        sweep("R1");
        read_all("R1/R8");

        // R4/R5: queue reversed mapping, routing must not move
        for (int o = 0; o < N; o++) wr({2'b00, 6'(o)}, 6'(N-1-o));
        sweep("R5");
        read_all("R4/R8");

        // R6/R2: apply at once
        wr(8'h80, 6'h3F);
        sweep("R6/R2");
        read_all("R6");
        wr(8'h80, 6'd0);  // repeat with nothing new
        sweep("R6 repeat");

        // R3: all outputs on input 5
        for (int o = 0; o < N; o++) wr({2'b00, 6'(o)}, 6'd5);
        wr(8'h80, 6'd0);
        din = N'(1) << 5;  #1 check("R3 fanout ones", dout, {N{1'b1}});
        din = ~(N'(1) << 5); #1 check("R3 fanout zeros", dout, '0);
        sweep("R3");

        // R7: rejected writes
        for (int o = 0; o < N; o++) wr({2'b00, 6'(o)}, 6'((o * 7) % N));
        wr({2'b00, 6'd34}, 6'd1);
        wr({2'b00, 6'd63}, 6'd2);
        wr({2'b00, 6'd0},  6'd34);
        wr({2'b00, 6'd1},  6'd63);
        wr({2'b01, 6'd2},  6'd9);
        wr({2'b11, 6'd3},  6'd9);
        wr({2'b10, 6'd1},  6'd0);   // not the configure address
        sweep("R7 outputs");
        read_all("R7");
        wr(8'h80, 6'd0);
        sweep("R7 after cfg");

        // R8: out-of-range and non-bank reads return 0
        access(1'b0, 1'b1, {2'b00, 6'd40}, 6'd0, rv); check("R8 idx range", rv, 0);
        access(1'b0, 1'b1, 8'h80, 6'd0, rv);          check("R8 ctrl space", rv, 0);
        access(1'b0, 1'b1, {2'b11, 6'd4}, 6'd0, rv);  check("R8 rsvd space", rv, 0);
        access(1'b0, 1'b1, {2'b00, 6'd3}, 6'd0, rv);
        repeat (2) @(negedge clk);
        check("R8 hold", rd_data, exp_pend[3]);

        // R9: read and write the same pending entry in one cycle
        for (int o = 0; o < N; o += 5) begin
            int old_v;
            old_v = exp_pend[o];
            access(1'b1, 1'b1, {2'b00, 6'(o)}, 6'(N-1-(o % 7)), rv);
            check("R9 old value", rv, old_v);
            access(1'b0, 1'b1, {2'b00, 6'(o)}, 6'd0, rv);
            check("R9 new value", rv, exp_pend[o]);
        end
        wr(8'h80, 6'd0);
        sweep("R9 routing");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule